// File: doc/BRIEF.md
# Packet-Framed Dual-Clock Stream FIFO

This block carries a valid/ready byte stream from one clock domain into a second, unrelated clock domain. Every stored entry holds the 8-bit payload together with its start-of-packet and end-of-packet markers. Packet boundaries therefore reach the far side on the same bytes they were written with.

A producer drives the sink port in the write domain, and a consumer takes words from the source port in the read domain. A word is transferred on a port only on a clock edge of that port's domain where valid and ready are both high. Each domain has its own active-low asynchronous reset.

Occupancy is tracked with binary counters that carry an extra wrap bit. Their Gray-coded images cross to the opposite domain through two-flop synchronizers. From these, the write side derives "full", which deasserts sink ready, and the read side derives "empty", which deasserts source valid.

Top module: `pkt_afifo`

## Requirements
- R1: While reset and immediately after it, `snk_ready` is 1 and `src_valid` is 0.
- R2: A sink word is taken only on a write-clock edge where `snk_valid` and `snk_ready` are both 1. A word offered while `snk_ready` is 0 never appears at the source and does not move the write pointer.
- R3: Words leave the source in the order they were accepted, with `src_data` equal to the accepted `snk_data`. This holds for unrelated clocks (write period 8 ns, read period 5 ns), including a reader that keeps ready low for its first 10 cycles.
- R4: `src_first` and `src_last` equal the `snk_first` and `snk_last` values that were accepted with the same word.
- R5: Once DEPTH words (16 by default) have been accepted and none read, `snk_ready` is 0. It returns to 1 after reads free space.
- R6: `src_valid` is 0 whenever no unread word is stored, and the read pointer does not move while `src_valid` is 0.
- R7: While `src_valid` is 1 and `src_ready` is 0, `src_valid` stays 1 and `src_data`, `src_first` and `src_last` hold their values on the next read edge.
- R8: Each pointer that crosses domains changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| snk_valid | input | 1 | Sink word offered |
| snk_ready | output | 1 | Sink can accept (not full) |
| snk_first | input | 1 | Sink word starts a packet |
| snk_last | input | 1 | Sink word ends a packet |
| snk_data | input | 8 | Sink payload |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| src_valid | output | 1 | Source word available (not empty) |
| src_ready | input | 1 | Consumer takes the word |
| src_first | output | 1 | Source word starts a packet |
| src_last | output | 1 | Source word ends a packet |
| src_data | output | 8 | Source payload |

## Verification
The bound checker watches four things on every edge of the relevant domain: the write pointer stays frozen while a word is refused, the read pointer stays frozen while the source shows nothing, the head word holds steady under back-pressure, and both Gray pointers step by at most one bit. Only the bench scenarios can show the end-to-end properties. These are that packet bytes and their start/end markers emerge intact and in order across the two clocks, that full is reached after exactly DEPTH words, and that a refused word is truly lost rather than delayed.

// File: rtl/pkt_afifo_pkg.sv
`timescale 1ns/1ps
package pkt_afifo_pkg;
  localparam int PKT_DATA_W = 8;

  typedef struct packed {
    logic                  sop;
    logic                  eop;
    logic [PKT_DATA_W-1:0] data;
  } pkt_entry_t;
endpackage

// File: rtl/pkt_afifo_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a Gray-coded pointer bus.
module pkt_afifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign q_out = sync_q;
endmodule

// File: rtl/pkt_afifo_mem.sv
`timescale 1ns/1ps
// Dual-port entry storage: clocked write, combinational read.
module pkt_afifo_mem
  import pkt_afifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        wr_clk,
  input  logic        wr_en,
  input  logic [AW-1:0] wr_addr,
  input  pkt_entry_t  wr_entry,
  input  logic [AW-1:0] rd_addr,
  output pkt_entry_t  rd_entry
);
  pkt_entry_t store_q [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      store_q[wr_addr] <= wr_entry;
    end
  end

  assign rd_entry = store_q[rd_addr];
endmodule

// File: rtl/pkt_afifo_ptr.sv
`timescale 1ns/1ps
// One side's pointer: binary count plus Gray image, and the space flag.
// IS_WRITE=1 builds the not-full test, IS_WRITE=0 the not-empty test.
module pkt_afifo_ptr #(
  parameter int DEPTH    = 16,
  parameter bit IS_WRITE = 1'b1,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [PW-1:0] peer_gray,
  output logic          avail,
  output logic          adv,
  output logic [AW-1:0] addr,
  output logic [PW-1:0] gray
);
  logic [PW-1:0] bin_q, bin_d;
  logic [PW-1:0] gray_q, gray_d;

  assign adv = req & avail;

  always_comb begin
    bin_d  = bin_q + {{(PW-1){1'b0}}, 1'b1};
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (adv) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  generate
    if (IS_WRITE) begin : g_full
      // Full: top two bits inverted, rest equal.
      assign avail = (gray_q != {~peer_gray[PW-1:PW-2], peer_gray[PW-3:0]});
    end else begin : g_empty
      assign avail = (gray_q != peer_gray);
    end
  endgenerate

  assign addr = bin_q[AW-1:0];
  assign gray = gray_q;
endmodule

// File: rtl/pkt_afifo.sv
`timescale 1ns/1ps
module pkt_afifo
  import pkt_afifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                  wr_clk,
  input  logic                  wr_rst_n,
  input  logic                  snk_valid,
  output logic                  snk_ready,
  input  logic                  snk_first,
  input  logic                  snk_last,
  input  logic [PKT_DATA_W-1:0] snk_data,
  input  logic                  rd_clk,
  input  logic                  rd_rst_n,
  output logic                  src_valid,
  input  logic                  src_ready,
  output logic                  src_first,
  output logic                  src_last,
  output logic [PKT_DATA_W-1:0] src_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_gray_w, rd_gray_w;
  logic [PW-1:0] wr_gray_in_rd, rd_gray_in_wr;
  logic          wr_adv, rd_adv;
  pkt_entry_t    wr_entry, rd_entry;

  assign wr_entry.sop  = snk_first;
  assign wr_entry.eop  = snk_last;
  assign wr_entry.data = snk_data;

  pkt_afifo_ptr #(.DEPTH(DEPTH), .IS_WRITE(1'b1)) wptr_i (
    .clk(wr_clk), .rst_n(wr_rst_n), .req(snk_valid), .peer_gray(rd_gray_in_wr),
    .avail(snk_ready), .adv(wr_adv), .addr(wr_addr), .gray(wr_gray_w)
  );

  pkt_afifo_ptr #(.DEPTH(DEPTH), .IS_WRITE(1'b0)) rptr_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .req(src_ready), .peer_gray(wr_gray_in_rd),
    .avail(src_valid), .adv(rd_adv), .addr(rd_addr), .gray(rd_gray_w)
  );

  pkt_afifo_sync #(.W(PW)) w2r_i (
    .clk(rd_clk), .rst_n(rd_rst_n), .d_in(wr_gray_w), .q_out(wr_gray_in_rd)
  );

  pkt_afifo_sync #(.W(PW)) r2w_i (
    .clk(wr_clk), .rst_n(wr_rst_n), .d_in(rd_gray_w), .q_out(rd_gray_in_wr)
  );

  pkt_afifo_mem #(.DEPTH(DEPTH)) mem_i (
    .wr_clk(wr_clk), .wr_en(wr_adv), .wr_addr(wr_addr), .wr_entry(wr_entry),
    .rd_addr(rd_addr), .rd_entry(rd_entry)
  );

  assign src_first = rd_entry.sop;
  assign src_last  = rd_entry.eop;
  assign src_data  = rd_entry.data;

  logic unused_rd_adv;
  assign unused_rd_adv = rd_adv;
endmodule

// File: rtl/pkt_afifo_chk.sv
`timescale 1ns/1ps
module pkt_afifo_chk #(
  parameter int PW = 5
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          snk_valid,
  input logic          snk_ready,
  input logic          src_valid,
  input logic          src_ready,
  input logic          src_first,
  input logic          src_last,
  input logic [7:0]    src_data,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] rd_gray
);
  // R2
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (snk_valid && !snk_ready) |=> $stable(wr_gray));

  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !src_valid |=> $stable(rd_gray));

  // R7
  src_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (src_valid && !src_ready) |=> (src_valid && $stable(src_data)
                                   && $stable(src_first) && $stable(src_last)));

  // R8
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R8
  rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind pkt_afifo pkt_afifo_chk #(.PW(PW)) chk_i (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .snk_valid(snk_valid), .snk_ready(snk_ready), .src_valid(src_valid),
  .src_ready(src_ready), .src_first(src_first), .src_last(src_last),
  .src_data(src_data), .wr_gray(wr_gray_w), .rd_gray(rd_gray_w)
);

// File: tb/pkt_afifo_tb_top.sv
`timescale 1ns/1ps
module pkt_afifo_tb_top;
  localparam int DEPTH = 16;

  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst_n, rd_rst_n;
  logic       snk_valid, snk_first, snk_last;
  logic [7:0] snk_data;
  logic       snk_ready;
  logic       src_valid, src_first, src_last;
  logic [7:0] src_data;
  logic       src_ready;

  int n_chk = 0;
  int n_bad = 0;
  int rd_mode = 1;          // 0 always ready, 1 stalled, 2 pseudo-random
  logic [7:0] rd_lfsr = 8'h5A;
  logic [9:0] exp_q[$];     // {first, last, data}
  bit done = 0;

  always #2.5 rd_clk = ~rd_clk;   // 200 MHz read clock
  always #4   wr_clk = ~wr_clk;   // keeps the 16:10 write/read period ratio

  pkt_afifo #(.DEPTH(DEPTH)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .snk_first(snk_first), .snk_last(snk_last), .snk_data(snk_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_first(src_first), .src_last(src_last), .src_data(src_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: choose ready for the coming edge, then score the transfer it makes.
  always @(negedge rd_clk) begin
    case (rd_mode)
      0: src_ready = 1'b1;
      1: src_ready = 1'b0;
      default: begin
        src_ready = rd_lfsr[0] | rd_lfsr[3];
        rd_lfsr   = {rd_lfsr[6:0], rd_lfsr[7] ^ rd_lfsr[5] ^ rd_lfsr[4] ^ rd_lfsr[3]};
      end
    endcase
    if (rd_rst_n && src_valid && src_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected word", {src_first, src_last, src_data}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(src_data == e[7:0], "R3 data/order", src_data, e[7:0]);
        chk({src_first, src_last} == e[9:8], "R4 first/last", {src_first, src_last}, e[9:8]);
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic f, input logic l);
    snk_valid = 1'b1; snk_data = d; snk_first = f; snk_last = l;
    while (!snk_ready) @(negedge wr_clk);
    exp_q.push_back({f, l, d});
    @(negedge wr_clk);
  endtask

  task automatic idle(input int n);
    snk_valid = 1'b0; snk_first = 1'b0; snk_last = 1'b0; snk_data = 8'h00;
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 4000) begin
      @(negedge rd_clk);
      t++;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge rd_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] wl;
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    snk_valid = 1'b0; snk_first = 1'b0; snk_last = 1'b0; snk_data = 8'h00;
    repeat (4) @(negedge wr_clk);
    chk(snk_ready == 1'b1, "R1 snk_ready in reset", snk_ready, 1);
    chk(src_valid == 1'b0, "R1 src_valid in reset", src_valid, 0);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    rd_mode = 0;
    repeat (2) @(negedge wr_clk);
    chk(snk_ready == 1'b1, "R1 snk_ready after reset", snk_ready, 1);
    repeat (20) begin
      @(negedge rd_clk);
      chk(src_valid == 1'b0, "R6 empty after reset", src_valid, 0);
    end

    // Packet with a stalled reader for its first 10 cycles (R3, R4).
    @(negedge wr_clk);
    fork
      begin
        rd_mode = 1;
        repeat (10) @(negedge rd_clk);
        rd_mode = 0;
      end
      begin
        send(8'hAA, 1'b1, 1'b0);
        send(8'hBB, 1'b0, 1'b0);
        send(8'hCC, 1'b0, 1'b0);
        send(8'hDD, 1'b0, 1'b0);
        idle(4);
        send(8'h55, 1'b0, 1'b0);
        send(8'hFF, 1'b0, 1'b1);
        idle(1);
      end
    join
    drain("R3 packet drained");

    // Fill to full with the reader stalled (R5, R2, R7).
    rd_mode = 1;
    repeat (4) @(negedge wr_clk);
    for (int i = 0; i < DEPTH; i++) send(8'h10 + 8'(i), i == 0, i == DEPTH - 1);
    idle(4);
    chk(snk_ready == 1'b0, "R5 full after DEPTH words", snk_ready, 0);
    snk_valid = 1'b1; snk_data = 8'h99; snk_first = 1'b1; snk_last = 1'b1;
    repeat (6) begin
      @(negedge wr_clk);
      chk(snk_ready == 1'b0, "R2 ready low while offered", snk_ready, 0);
    end
    idle(1);
    repeat (5) begin
      @(negedge rd_clk);
      chk(src_valid && src_data == exp_q[0][7:0], "R7 head held", src_data, exp_q[0][7:0]);
    end
    rd_mode = 0;
    drain("R2 refused word absent");
    repeat (10) @(negedge rd_clk);
    chk(src_valid == 1'b0, "R6 empty after drain", src_valid, 0);
    repeat (6) @(negedge wr_clk);
    chk(snk_ready == 1'b1, "R5 space after reads", snk_ready, 1);

    // Random back-pressure and bursty writes (R3, R4, R8).
    rd_mode = 2;
    wl = 8'h3C;
    for (int i = 0; i < 48; i++) begin
      send(wl, (i % 8) == 0, (i % 8) == 7);
      wl = {wl[6:0], wl[7] ^ wl[5] ^ wl[4] ^ wl[3]};
      if (wl[1:0] == 2'b00) idle(2);
    end
    idle(1);
    drain("R3 R8 random crossing drained");
    rd_mode = 0;
    repeat (10) @(negedge rd_clk);
    chk(src_valid == 1'b0, "R6 empty at end", src_valid, 0);

    done = 1;
    finish_run();
  end
endmodule